// File: doc/BRIEF.md
# Measurement Slot Sequencer

This controller steps an analog measurement multiplexer through a repeating list of slots, driven by a single select line that an external converter toggles. Each monitored supply has two slots: its bus voltage comes first and its shunt current second. The supplies are visited in ascending order, and the list wraps around after the last slot. The select input is asynchronous. It passes through a synchronizer, and every rising transition advances the sequence by one slot.

The sequencer starts cycling only after an arming pattern: a pulse on the select line, then a quiet low gap of qualified length, then a rising transition. If the line stays at one level for too long, the block falls back to standby. An enable input holds the block in standby unless it reads fully functional. A mode input picks stand-alone operation or one side of a pair. In a pair, two instances share one output and take turns: the first device owns the first half of the slots and the second device owns the rest. A per-channel present mask shortens the list at the first absent channel.

All timing windows are measured in ticks, where one tick is `TICK_DIV` clock cycles. The bench can therefore run in scaled time.

Top module: `meas_slot_seq`

## Requirements
- R1: Slot s refers to channel index floor(s/2) within the owning device's half, counted from 0 for the first channel. Bit 0 of the slot gives the kind: 0 is bus voltage, 1 is shunt current. In stand-alone mode the slot runs 0, 1, ..., 2n-1 and then wraps to 0, where n is the number of active channels.
- R2: While running, each rising transition of `sel_raw` advances `slot_idx` by exactly one. The output changes on the third rising clock edge counted from the first edge that samples the new high level.
- R3: After reset and while not running, `slot_idx`, `ch_sel` and `kind_sel` are 0 and `drive_en` is 0.
- R4: A falling select transition while unarmed starts a gap. A rising transition that ends the gap arms the sequencer only if the hold count at that moment lies in [ARM_MIN, ARM_MAX]. The hold count is the number of whole ticks since the last synchronized transition. When the sequencer arms, it starts at slot 0 with `drive_en` set (when the device owns slot 0).
- R5: A gap whose hold count falls outside the window leaves the sequencer unarmed. A later pulse followed by a gap inside the window arms it.
- R6: While gapping or running, if the hold count reaches TIMEOUT ticks with the select line high or low, the sequencer returns to standby: slot 0 and `drive_en` 0.
- R7: `en_state` encoding: 00 is fully functional, 01 is limited function, 10 and 11 are standby. Any value other than 00 forces standby on the next clock. Once enable returns to 00, the sequencer stays in standby until it is armed again.
- R8: `mode` encoding: 00 is first device of a pair, 10 is second device, 01 and 11 are stand-alone. When paired there are 4n slots. The first device asserts `drive_en` only for slots below 2n, and the second device only for slots 2n and above. The channel index restarts at 0 in the second half.
- R9: Channel i is active only if `ch_present` bits 0..i are all 1. A clear bit drops that channel and every higher channel. With no active channel the sequencer never arms.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; asserts asynchronously, release is expected to be synchronous |
| sel_raw | input | 1 | Asynchronous select line from the converter |
| en_state | input | 2 | Enable level: 00 full, 01 limited, 10/11 standby |
| mode | input | 2 | Role: 00 first of pair, 10 second of pair, 01/11 stand-alone |
| ch_present | input | N_CH | Per-channel present flags, bit 0 = first channel |
| slot_idx | output | $clog2(4*N_CH) | Current slot number |
| ch_sel | output | CH_W | Channel index of the current slot within the owning device |
| kind_sel | output | 1 | 0 = bus voltage, 1 = shunt current |
| drive_en | output | 1 | Shared output driver enable; 0 means high impedance |

## Verification
A select transition first affects the state on the third rising edge after `sel_raw` is sampled at its new level, and the slot outputs move on that same edge. A change of `en_state` takes effect on the next edge. A timeout lands about TIMEOUT*TICK_DIV plus three cycles after the last raw transition. The bench's behavioural model tracks the two-stage synchronizer delay and the elapsed-cycle count itself, updates at each rising edge, and is compared with the outputs a few nanoseconds later. The directed checks sample at falling edges, and the waits before them are chosen so that the expected edge has already passed and any boundary is still some ticks away.

// File: rtl/slotseq_pkg.sv
package slotseq_pkg;

  typedef enum logic [1:0] {
    EN_FULL      = 2'b00,
    EN_LIMITED   = 2'b01,
    EN_STANDBY   = 2'b10,
    EN_STANDBY_X = 2'b11
  } en_lvl_e;

  typedef enum logic [1:0] {
    ROLE_FIRST  = 2'b00,
    ROLE_SOLO   = 2'b01,
    ROLE_SECOND = 2'b10,
    ROLE_SOLO_X = 2'b11
  } role_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'b00,
    ST_GAP  = 2'b01,
    ST_RUN  = 2'b10
  } seq_state_e;

endpackage

// File: rtl/slotseq_sync.sv
module slotseq_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sel_async,
  output logic rise,
  output logic fall
);
  logic [STAGES:0] chain_q, chain_d;

  always_comb chain_d = {chain_q[STAGES-1:0], sel_async};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rise =  chain_q[STAGES-1] & ~chain_q[STAGES];
  assign fall = ~chain_q[STAGES-1] &  chain_q[STAGES];
endmodule

// File: rtl/slotseq_gap_timer.sv
module slotseq_gap_timer #(
  parameter int TICK_DIV = 25000,
  parameter int HOLD_MAX = 140
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             restart,
  output logic [$clog2(HOLD_MAX+1)-1:0]    hold_ticks,
  output logic                             hold_full
);
  localparam int PRE_W  = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam int HOLD_W = $clog2(HOLD_MAX + 1);
  localparam logic [PRE_W-1:0]  PRE_LAST = PRE_W'(TICK_DIV - 1);
  localparam logic [HOLD_W-1:0] HOLD_TOP = HOLD_W'(HOLD_MAX);

  logic [PRE_W-1:0]  pre_q, pre_d;
  logic [HOLD_W-1:0] hold_q, hold_d;
  logic              tick;

  assign tick = (pre_q == PRE_LAST);

  always_comb begin
    pre_d  = pre_q;
    hold_d = hold_q;
    if (restart) begin
      pre_d  = '0;
      hold_d = '0;
    end else begin
      pre_d = tick ? '0 : pre_q + PRE_W'(1);
      if (tick && (hold_q != HOLD_TOP)) hold_d = hold_q + HOLD_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q  <= '0;
      hold_q <= '0;
    end else begin
      pre_q  <= pre_d;
      hold_q <= hold_d;
    end
  end

  assign hold_ticks = hold_q;
  assign hold_full  = (hold_q == HOLD_TOP);
endmodule

// File: rtl/slotseq_slot_map.sv
module slotseq_slot_map
  import slotseq_pkg::*;
#(
  parameter int N_CH   = 4,
  parameter int CH_W   = 3,
  parameter int SLOT_W = 4
) (
  input  logic [N_CH-1:0]   present,
  input  logic [1:0]        mode,
  input  logic [SLOT_W-1:0] slot,
  output logic [SLOT_W:0]   total,
  output logic [CH_W-1:0]   ch,
  output logic              kind,
  output logic              own
);
  localparam int TOT_W = SLOT_W + 1;

  logic [N_CH:0]    chain;
  logic [TOT_W-1:0] live, span, pos, local_pos;
  role_e            role;
  logic             paired, upper;

  assign chain[0] = 1'b1;
  for (genvar g = 0; g < N_CH; g++) begin : g_prefix
    assign chain[g+1] = chain[g] & present[g];
  end

  always_comb begin
    live      = TOT_W'($countones(chain[N_CH:1]));
    span      = live << 1;
    role      = role_e'(mode);
    paired    = (role == ROLE_FIRST) || (role == ROLE_SECOND);
    total     = paired ? (span << 1) : span;
    pos       = {1'b0, slot};
    upper     = (pos >= span);
    local_pos = (paired && upper) ? (pos - span) : pos;
    ch        = CH_W'(local_pos >> 1);
    kind      = slot[0];
    own       = !paired || ((role == ROLE_FIRST) && !upper) ||
                ((role == ROLE_SECOND) && upper);
  end
endmodule

// File: rtl/meas_slot_seq.sv
module meas_slot_seq
  import slotseq_pkg::*;
#(
  parameter int N_CH        = 4,
  parameter int CH_W        = 3,
  parameter int TICK_DIV    = 25000,
  parameter int ARM_MIN     = 59,
  parameter int ARM_MAX     = 97,
  parameter int TIMEOUT     = 140,
  parameter int SYNC_STAGES = 2
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        sel_raw,
  input  logic [1:0]                  en_state,
  input  logic [1:0]                  mode,
  input  logic [N_CH-1:0]             ch_present,
  output logic [$clog2(4*N_CH)-1:0]   slot_idx,
  output logic [CH_W-1:0]             ch_sel,
  output logic                        kind_sel,
  output logic                        drive_en
);
  localparam int SLOT_W = $clog2(4 * N_CH);
  localparam int TOT_W  = SLOT_W + 1;
  localparam int HOLD_W = $clog2(TIMEOUT + 1);

  logic              sel_rise, sel_fall;
  logic [HOLD_W-1:0] hold_ticks;
  logic              hold_full, in_win, run_allowed;
  logic [TOT_W-1:0]  total_slots, slot_inc;
  logic              map_own;

  seq_state_e        st_q, st_d;
  logic [SLOT_W-1:0] slot_q, slot_d;

  slotseq_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .sel_async(sel_raw),
    .rise(sel_rise), .fall(sel_fall)
  );

  slotseq_gap_timer #(.TICK_DIV(TICK_DIV), .HOLD_MAX(TIMEOUT)) u_timer (
    .clk(clk), .rst_n(rst_n), .restart(sel_rise | sel_fall),
    .hold_ticks(hold_ticks), .hold_full(hold_full)
  );

  slotseq_slot_map #(.N_CH(N_CH), .CH_W(CH_W), .SLOT_W(SLOT_W)) u_map (
    .present(ch_present), .mode(mode), .slot(slot_q),
    .total(total_slots), .ch(ch_sel), .kind(kind_sel), .own(map_own)
  );

  assign run_allowed = (en_lvl_e'(en_state) == EN_FULL);
  assign in_win      = (hold_ticks >= HOLD_W'(ARM_MIN)) &&
                       (hold_ticks <= HOLD_W'(ARM_MAX));
  assign slot_inc    = {1'b0, slot_q} + TOT_W'(1);

  always_comb begin
    st_d   = st_q;
    slot_d = slot_q;
    if (!run_allowed) begin
      st_d   = ST_IDLE;
      slot_d = '0;
    end else begin
      case (st_q)
        ST_IDLE: if (sel_fall) st_d = ST_GAP;
        ST_GAP: begin
          slot_d = '0;
          if (hold_full) st_d = ST_IDLE;
          else if (sel_rise)
            st_d = (in_win && (total_slots != '0)) ? ST_RUN : ST_IDLE;
        end
        ST_RUN: begin
          if (hold_full) begin
            st_d   = ST_IDLE;
            slot_d = '0;
          end else if (sel_rise) begin
            slot_d = (slot_inc >= total_slots) ? '0 : slot_inc[SLOT_W-1:0];
          end
        end
        default: begin
          st_d   = ST_IDLE;
          slot_d = '0;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      slot_q <= '0;
    end else begin
      st_q   <= st_d;
      slot_q <= slot_d;
    end
  end

  assign slot_idx = slot_q;
  assign drive_en = (st_q == ST_RUN) && map_own;
endmodule

// File: rtl/meas_slot_seq_chk.sv
module meas_slot_seq_chk #(
  parameter int SLOT_W   = 4,
  parameter int CH_W     = 3,
  parameter int TICK_DIV = 25000,
  parameter int TIMEOUT  = 140
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sel_raw,
  input logic [1:0]        en_state,
  input logic [1:0]        mode,
  input logic [SLOT_W-1:0] slot_idx,
  input logic [CH_W-1:0]   ch_sel,
  input logic              kind_sel,
  input logic              drive_en
);
  localparam logic [31:0] QUIET_LIMIT = 32'(TIMEOUT * TICK_DIV + 16);

  logic        sel_seen_q;
  logic [31:0] quiet_q, quiet_d;

  always_comb begin
    if (sel_raw != sel_seen_q) quiet_d = '0;
    else if (quiet_q != '1)    quiet_d = quiet_q + 32'd1;
    else                       quiet_d = quiet_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_seen_q <= 1'b0;
      quiet_q    <= '0;
    end else begin
      sel_seen_q <= sel_raw;
      quiet_q    <= quiet_d;
    end
  end

  p_standby_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (en_state != 2'b00) |=> (!drive_en && (slot_idx == '0)));

  p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_idx != $past(slot_idx)) |->
      ((slot_idx == $past(slot_idx) + SLOT_W'(1)) || (slot_idx == '0)));

  p_pair_kind_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(kind_sel) |-> $stable(ch_sel));

  p_arm_start_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(drive_en) && (mode == 2'b01) && $stable(mode)) |-> (slot_idx == '0));

  p_stuck_line_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (quiet_q > QUIET_LIMIT) |-> !drive_en);
endmodule

bind meas_slot_seq meas_slot_seq_chk #(
  .SLOT_W(SLOT_W), .CH_W(CH_W), .TICK_DIV(TICK_DIV), .TIMEOUT(TIMEOUT)
) u_chk (
  .clk(clk), .rst_n(rst_n), .sel_raw(sel_raw), .en_state(en_state),
  .mode(mode), .slot_idx(slot_idx), .ch_sel(ch_sel),
  .kind_sel(kind_sel), .drive_en(drive_en)
);

// File: tb/tb_meas_slot_seq.sv
module tb_meas_slot_seq;
  localparam int N_CH     = 4;
  localparam int CH_W     = 3;
  localparam int TICK_DIV = 4;
  localparam int ARM_MIN  = 59;
  localparam int ARM_MAX  = 97;
  localparam int TIMEOUT  = 140;
  localparam int SLOT_W   = $clog2(4 * N_CH);

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              sel_raw = 1'b0;
  logic [1:0]        en_state = 2'b00;
  logic [1:0]        mode = 2'b01;
  logic [N_CH-1:0]   ch_present = '1;
  logic [SLOT_W-1:0] slot_idx;
  logic [CH_W-1:0]   ch_sel;
  logic              kind_sel, drive_en;

  always #5 clk = ~clk;

  meas_slot_seq #(
    .N_CH(N_CH), .CH_W(CH_W), .TICK_DIV(TICK_DIV),
    .ARM_MIN(ARM_MIN), .ARM_MAX(ARM_MAX), .TIMEOUT(TIMEOUT)
  ) dut (
    .clk(clk), .rst_n(rst_n), .sel_raw(sel_raw), .en_state(en_state),
    .mode(mode), .ch_present(ch_present), .slot_idx(slot_idx),
    .ch_sel(ch_sel), .kind_sel(kind_sel), .drive_en(drive_en)
  );

  int    checks = 0;
  int    errors = 0;
  int    cyc = 0;
  bit    done = 1'b0;
  string cur_req = "R3";

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  bit m_d1, m_d2, m_d3;
  int m_elapsed, m_state, m_slot;   // state: 0 standby, 1 gap, 2 running

  function automatic int live_count();
    int n = 0;
    for (int i = 0; i < N_CH; i++) begin
      if (!ch_present[i]) break;
      n++;
    end
    return n;
  endfunction

  function automatic bit is_paired();
    return (mode == 2'b00) || (mode == 2'b10);
  endfunction

  function automatic int total_slots();
    return is_paired() ? 4 * live_count() : 2 * live_count();
  endfunction

  task automatic compare();
    int  n = live_count();
    bit  upper = (m_slot >= 2 * n);
    int  loc = (is_paired() && upper) ? m_slot - 2 * n : m_slot;
    bit  own = !is_paired() || (mode == 2'b00 && !upper) || (mode == 2'b10 && upper);
    chk(cur_req, "model slot_idx", int'(slot_idx), m_slot);
    chk(cur_req, "model ch_sel", int'(ch_sel), loc / 2);
    chk(cur_req, "model kind_sel", int'(kind_sel), m_slot % 2);
    chk(cur_req, "model drive_en", int'(drive_en), int'((m_state == 2) && own));
  endtask

  always @(posedge clk) begin
    bit rise, fall;
    int hold;
    if (!rst_n) begin
      m_d1 = 0; m_d2 = 0; m_d3 = 0;
      m_elapsed = 0; m_state = 0; m_slot = 0;
    end else begin
      rise = m_d2 && !m_d3;
      fall = !m_d2 && m_d3;
      hold = m_elapsed / TICK_DIV;
      if (hold > TIMEOUT) hold = TIMEOUT;
      if (en_state != 2'b00) begin
        m_state = 0; m_slot = 0;
      end else if (m_state == 0) begin
        if (fall) m_state = 1;
      end else if (hold == TIMEOUT) begin
        m_state = 0; m_slot = 0;
      end else if (m_state == 1) begin
        if (rise) begin
          m_slot  = 0;
          m_state = (hold >= ARM_MIN && hold <= ARM_MAX && total_slots() > 0) ? 2 : 0;
        end
      end else if (rise) begin
        m_slot = m_slot + 1;
        if (m_slot >= total_slots()) m_slot = 0;
      end
      if (rise || fall) m_elapsed = 0;
      else if (m_elapsed < (TIMEOUT + 2) * TICK_DIV) m_elapsed++;
      m_d3 = m_d2; m_d2 = m_d1; m_d1 = sel_raw;
    end
    #3;
    if (!done) compare();
  end

  // ---------------- watchdog ----------------
  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000 && !done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL %s watchdog: actual %0d expected %0d cycles", cur_req, cyc, 100000);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  // ---------------- stimulus ----------------
  task automatic wait_cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic step();
    sel_raw = 1'b1; wait_cyc(20);
    sel_raw = 1'b0; wait_cyc(20);
  endtask

  task automatic arm(int gap);
    sel_raw = 1'b1; wait_cyc(20);
    sel_raw = 1'b0; wait_cyc(gap);
    sel_raw = 1'b1; wait_cyc(20);
    sel_raw = 1'b0; wait_cyc(20);
  endtask

  task automatic restart(logic [1:0] m, logic [N_CH-1:0] p);
    @(negedge clk);
    rst_n = 1'b0; sel_raw = 1'b0; en_state = 2'b00;
    mode = m; ch_present = p;
    wait_cyc(3);
    rst_n = 1'b1;
    wait_cyc(3);
  endtask

  initial begin
    // R3: reset state
    cur_req = "R3";
    wait_cyc(4);
    rst_n = 1'b1;
    wait_cyc(5);
    chk("R3", "drive_en after reset", drive_en, 0);
    chk("R3", "slot_idx after reset", slot_idx, 0);
    chk("R3", "ch_sel after reset", ch_sel, 0);
    chk("R3", "kind_sel after reset", kind_sel, 0);

    // R4: arming with a gap inside the window (300 cycles = 75 ticks)
    cur_req = "R4";
    arm(300);
    chk("R4", "drive_en after arming", drive_en, 1);
    chk("R4", "slot_idx after arming", slot_idx, 0);

    // R2: output moves on the third edge after the new level is sampled
    cur_req = "R2";
    sel_raw = 1'b1;
    wait_cyc(2);
    chk("R2", "slot_idx two edges after rise", slot_idx, 0);
    wait_cyc(1);
    chk("R2", "slot_idx three edges after rise", slot_idx, 1);
    chk("R1", "kind of slot 1 is shunt", kind_sel, 1);
    chk("R1", "channel of slot 1", ch_sel, 0);
    wait_cyc(17);
    sel_raw = 1'b0; wait_cyc(20);

    // R1: ordering and wrap, 4 channels -> 8 slots
    cur_req = "R1";
    for (int k = 2; k <= 9; k++) begin
      step();
      chk("R1", "slot_idx sequence", slot_idx, k % 8);
      chk("R1", "ch_sel sequence", ch_sel, (k % 8) / 2);
      chk("R1", "kind_sel sequence", kind_sel, k % 2);
    end

    // R6: timeout with the line held low (560 cycles)
    cur_req = "R6";
    wait_cyc(500);
    chk("R6", "still driving before timeout", drive_en, 1);
    wait_cyc(100);
    chk("R6", "drive_en after low timeout", drive_en, 0);
    chk("R6", "slot_idx after low timeout", slot_idx, 0);

    // R6: timeout with the line held high
    restart(2'b01, 4'b1111);
    arm(300);
    chk("R6", "armed before high hold", drive_en, 1);
    sel_raw = 1'b1;
    wait_cyc(700);
    chk("R6", "drive_en after high timeout", drive_en, 0);
    sel_raw = 1'b0; wait_cyc(20);

    // R5: gap too short, gap too long, then a fresh pulse with a good gap
    cur_req = "R5";
    restart(2'b01, 4'b1111);
    arm(100);
    chk("R5", "short gap leaves unarmed", drive_en, 0);
    arm(500);
    chk("R5", "long gap leaves unarmed", drive_en, 0);
    arm(300);
    chk("R5", "fresh pulse and good gap arms", drive_en, 1);

    // R7: enable levels
    cur_req = "R7";
    en_state = 2'b01;
    wait_cyc(1);
    chk("R7", "limited function forces standby", drive_en, 0);
    en_state = 2'b00;
    step();
    chk("R7", "stays in standby after enable returns", drive_en, 0);
    chk("R7", "slot held at 0 in standby", slot_idx, 0);
    arm(300);
    chk("R7", "rearmed with enable low", drive_en, 1);
    en_state = 2'b10;
    wait_cyc(1);
    chk("R7", "standby level forces standby", drive_en, 0);
    en_state = 2'b01;
    arm(300);
    chk("R7", "cannot arm in limited function", drive_en, 0);
    en_state = 2'b00;

    // R9: truncation at the first absent channel (1011 -> 2 channels)
    cur_req = "R9";
    restart(2'b01, 4'b1011);
    arm(300);
    chk("R9", "armed with two channels", drive_en, 1);
    repeat (3) step();
    chk("R9", "slot 3 channel", ch_sel, 1);
    chk("R9", "slot 3 kind", kind_sel, 1);
    step();
    chk("R9", "wrap after 4 slots", slot_idx, 0);
    restart(2'b01, 4'b1110);
    arm(300);
    chk("R9", "no active channel never arms", drive_en, 0);

    // R8: first device of a pair, 3 channels -> 12 slots
    cur_req = "R8";
    restart(2'b00, 4'b0111);
    arm(300);
    chk("R8", "first device drives slot 0", drive_en, 1);
    repeat (5) step();
    chk("R8", "first device slot 5 channel", ch_sel, 2);
    chk("R8", "first device slot 5 drive", drive_en, 1);
    step();
    chk("R8", "first device releases at slot 6", drive_en, 0);
    chk("R8", "slot 6 index", slot_idx, 6);
    repeat (5) step();
    chk("R8", "slot 11 index", slot_idx, 11);
    step();
    chk("R8", "pair wraps after 12", slot_idx, 0);
    chk("R8", "first device drives again", drive_en, 1);

    // R8: second device of a pair
    restart(2'b10, 4'b0111);
    arm(300);
    chk("R8", "second device quiet at slot 0", drive_en, 0);
    repeat (6) step();
    chk("R8", "second device drives slot 6", drive_en, 1);
    chk("R8", "second device slot 6 channel", ch_sel, 0);
    chk("R8", "second device slot 6 kind", kind_sel, 0);
    repeat (5) step();
    chk("R8", "second device slot 11 channel", ch_sel, 2);
    chk("R8", "second device slot 11 kind", kind_sel, 1);
    step();
    chk("R8", "second device quiet after wrap", drive_en, 0);

    wait_cyc(5);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule